// File: doc/BRIEF.md
# Multiplexed External Bus Master

This block runs one read or one write cycle at a time on an external bus where the low address byte and the data byte use the same eight lines in turn. An active-low address strobe frames the address phase. An active-low data strobe frames the data phase. A read/write line and an active-low data-memory select tell the external device what kind of transfer this is. The upper address bits are driven on their own output for the whole cycle.

On the internal side a client raises `req_i` while `ready_o` is high. The block latches the address, write data, direction, memory-space flag and stretch flag in that same cycle. It then steps through fixed phases counted in clock periods: setup, strobe low, address hold, float, data setup, data strobe low, data strobe rise and done. When the cycle finishes, `done_o` pulses for one clock. On a read, the captured byte appears on `rdata_o` at the same time. If the stretch flag was set when the request was accepted, the data strobe stays low for extra clock periods.

Top module: `mbus_master`

## Requirements
- R1: After reset and whenever no cycle is in progress, `ready_o`=1, `as_n_o`=`ds_n_o`=`rw_n_o`=`dm_n_o`=1, `bus_oe_o`=0 and `done_o`=0. A request is accepted only when `req_i` and `ready_o` are both high. Changes on `req_i` and the request fields while a cycle is running have no effect on that cycle.
- R2: The address is driven on the shared lines with `bus_oe_o`=1 for one clock before `as_n_o` falls, for every clock it is low, and for one clock after it rises. `bus_o` carries `addr_i[7:0]` during this time, and `addr_hi_o` carries `addr_i[15:8]`.
- R3: `as_n_o` is low for exactly AS_CYC consecutive clocks (default 2), starting one clock after acceptance.
- R4: After `as_n_o` rises and the address clock ends, the lines are released (`bus_oe_o`=0) for one clock before any data is driven. `ds_n_o` is never low while `as_n_o` is low.
- R5: On a read, `bus_oe_o` stays 0 from the float clock through the end of the cycle. `rdata_o` takes the value of `bus_i` from the last clock in which `ds_n_o` is low, which is the edge where `ds_n_o` rises. A write leaves `rdata_o` unchanged.
- R6: On a write, `bus_o` carries the write byte with `bus_oe_o`=1 for one clock before `ds_n_o` falls, while it is low, and for one clock after it rises.
- R7: `ds_n_o` is low for RD_CYC clocks on a read (default 4) and WR_CYC clocks on a write (default 2). Both lengths grow by EXT_CYC clocks (default 2) when `ext_i` was 1 at acceptance.
- R8: `rw_n_o` is 1 for a read and 0 for a write (`wr_i`=1). `dm_n_o` is 0 when `mem_i`=1. Both hold their values from the clock before `as_n_o` falls through the clock after `ds_n_o` rises, and both are 1 otherwise.
- R9: `done_o` is high for exactly one clock. That clock is 6+AS_CYC+(data strobe length) clocks after the acceptance edge. `ready_o` returns high in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a cycle |
| ready_o | output | 1 | Idle, able to accept a request |
| wr_i | input | 1 | 1 = write, 0 = read |
| mem_i | input | 1 | 1 = data-memory space (drives select low) |
| ext_i | input | 1 | 1 = stretched data strobe |
| addr_i | input | ADDR_W | Cycle address |
| wdata_i | input | DATA_W | Write byte |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Last byte read |
| bus_o | output | DATA_W | Shared lines, outgoing value |
| bus_oe_o | output | 1 | Drive enable for the shared lines |
| bus_i | input | DATA_W | Shared lines, incoming value |
| addr_hi_o | output | ADDR_W-DATA_W | Upper address bits |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_n_o | output | 1 | 1 = read, 0 = write |
| dm_n_o | output | 1 | Data-memory select, active low |

## Verification
The assertions check on every clock the rules that hold between pins:
- the strobes are never low together;
- the lines are released during a read strobe;
- the address is still driven as the address strobe rises;
- write data is still driven as the data strobe rises;
- direction and space are stable under a data strobe;
- the address strobe has its exact width;
- the done pulse lasts one clock;
- the pins are quiet while idle.

The bench scenarios are the only way to show the behaviour that depends on the request. That covers the exact address and write byte on the lines, the captured read byte, the stretched and unstretched strobe lengths, the done latency, and the fact that requests made during a busy cycle are ignored.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_SETUP,
        PH_AS,
        PH_AHOLD,
        PH_FLOAT,
        PH_DSET,
        PH_DS,
        PH_DRISE,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/mbus_phase_ctr.sv
module mbus_phase_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_s;

    ctr_s ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d.cnt = load_val_i;
        end else if (ctr_q.cnt != '0) begin
            ctr_d.cnt = ctr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign last_o = (ctr_q.cnt == '0);

endmodule

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
#(
    parameter int AS_CYC  = 2,
    parameter int RD_CYC  = 4,
    parameter int WR_CYC  = 2,
    parameter int EXT_CYC = 2
) (
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   start_i,
    input  logic   wr_i,
    input  logic   ext_i,
    output phase_e ph_q_o,
    output phase_e ph_d_o
);

    localparam int DS_MAX  = ((RD_CYC > WR_CYC) ? RD_CYC : WR_CYC) + EXT_CYC;
    localparam int LEN_MAX = (DS_MAX > AS_CYC) ? DS_MAX : AS_CYC;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    typedef struct packed {
        phase_e ph;
        logic   wr;
        logic   ext;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    logic             last;
    logic             ld;
    logic [CNT_W-1:0] ld_val;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    fsm_d.ph  = PH_SETUP;
                    fsm_d.wr  = wr_i;
                    fsm_d.ext = ext_i;
                end
            end
            PH_SETUP: fsm_d.ph = PH_AS;
            PH_AS:    if (last) fsm_d.ph = PH_AHOLD;
            PH_AHOLD: fsm_d.ph = PH_FLOAT;
            PH_FLOAT: fsm_d.ph = PH_DSET;
            PH_DSET:  fsm_d.ph = PH_DS;
            PH_DS:    if (last) fsm_d.ph = PH_DRISE;
            PH_DRISE: fsm_d.ph = PH_DONE;
            PH_DONE:  fsm_d.ph = PH_IDLE;
            default:  fsm_d.ph = PH_IDLE;
        endcase
    end

    // Phase length counter, reloaded whenever the phase changes
    always_comb begin
        ld     = (fsm_d.ph != fsm_q.ph);
        ld_val = '0;
        if (fsm_d.ph == PH_AS) begin
            ld_val = CNT_W'(AS_CYC - 1);
        end else if (fsm_d.ph == PH_DS) begin
            ld_val = CNT_W'((fsm_d.wr ? WR_CYC : RD_CYC)
                          + (fsm_d.ext ? EXT_CYC : 0) - 1);
        end
    end

    mbus_phase_ctr #(
        .CNT_W (CNT_W)
    ) i_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (ld),
        .load_val_i (ld_val),
        .last_o     (last)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q <= '{ph: PH_IDLE, wr: 1'b0, ext: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ph_q_o = fsm_q.ph;
    assign ph_d_o = fsm_d.ph;

    AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.ph == PH_DONE) |=> (fsm_q.ph == PH_IDLE)); // R9

    AST_DS_AFTER_DSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fsm_q.ph == PH_DS) |-> ($past(fsm_q.ph) == PH_DSET)); // R4

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int AS_CYC = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     start_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic                     wr_i,
    input  logic                     mem_i,
    input  phase_e                   ph_q_i,
    input  phase_e                   ph_d_i,
    input  logic [DATA_W-1:0]        bus_i,
    output logic                     as_n_o,
    output logic                     ds_n_o,
    output logic                     rw_n_o,
    output logic                     dm_n_o,
    output logic                     oe_o,
    output logic [DATA_W-1:0]        bus_o,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic                     done_o
);

    localparam int RUN_W = $clog2(AS_CYC + 2);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic              mem;
        logic              as_n;
        logic              ds_n;
        logic              rw_n;
        logic              dm_n;
        logic              oe;
        logic [DATA_W-1:0] bus;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } pin_s;

    pin_s pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (start_i) begin
            pin_d.addr  = addr_i;
            pin_d.wdata = wdata_i;
            pin_d.wr    = wr_i;
            pin_d.mem   = mem_i;
        end
        pin_d.as_n = 1'b1;
        pin_d.ds_n = 1'b1;
        pin_d.rw_n = 1'b1;
        pin_d.dm_n = 1'b1;
        pin_d.oe   = 1'b0;
        pin_d.bus  = '0;
        pin_d.done = 1'b0;
        unique case (ph_d_i)
            PH_SETUP, PH_AS, PH_AHOLD: begin
                pin_d.as_n = (ph_d_i != PH_AS);
                pin_d.oe   = 1'b1;
                pin_d.bus  = pin_d.addr[DATA_W-1:0];
                pin_d.rw_n = ~pin_d.wr;
                pin_d.dm_n = ~pin_d.mem;
            end
            PH_FLOAT: begin
                pin_d.rw_n = ~pin_d.wr;
                pin_d.dm_n = ~pin_d.mem;
            end
            PH_DSET, PH_DS, PH_DRISE: begin
                pin_d.ds_n = (ph_d_i != PH_DS);
                pin_d.rw_n = ~pin_d.wr;
                pin_d.dm_n = ~pin_d.mem;
                if (pin_d.wr) begin
                    pin_d.oe  = 1'b1;
                    pin_d.bus = pin_d.wdata;
                end
            end
            PH_DONE: pin_d.done = 1'b1;
            default: ;
        endcase
        // Read byte taken on the edge that raises the data strobe
        if ((ph_q_i == PH_DS) && (ph_d_i == PH_DRISE) && !pin_q.wr) begin
            pin_d.rdata = bus_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_q      <= '0;
            pin_q.as_n <= 1'b1;
            pin_q.ds_n <= 1'b1;
            pin_q.rw_n <= 1'b1;
            pin_q.dm_n <= 1'b1;
        end else begin
            pin_q <= pin_d;
        end
    end

    assign as_n_o    = pin_q.as_n;
    assign ds_n_o    = pin_q.ds_n;
    assign rw_n_o    = pin_q.rw_n;
    assign dm_n_o    = pin_q.dm_n;
    assign oe_o      = pin_q.oe;
    assign bus_o     = pin_q.bus;
    assign addr_hi_o = pin_q.addr[ADDR_W-1:DATA_W];
    assign rdata_o   = pin_q.rdata;
    assign done_o    = pin_q.done;

    // Width of the address strobe, counted independently of the phase counter
    logic [RUN_W-1:0] as_run_d, as_run_q;

    always_comb begin
        as_run_d = pin_q.as_n ? '0 : as_run_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            as_run_q <= '0;
        end else begin
            as_run_q <= as_run_d;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ph_q_i == PH_IDLE) |-> (pin_q.as_n && pin_q.ds_n && !pin_q.oe
                                 && pin_q.rw_n && pin_q.dm_n && !pin_q.done)); // R1

    AST_ADDR_AT_AS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pin_q.as_n) |-> (pin_q.oe && $stable(pin_q.bus))); // R2

    AST_AS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pin_q.as_n) |-> (as_run_q == RUN_W'(AS_CYC))); // R3

    AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pin_q.ds_n |-> pin_q.as_n); // R4

    AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pin_q.ds_n && pin_q.rw_n) |-> !pin_q.oe); // R5

    AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(pin_q.ds_n) && !pin_q.rw_n) |-> (pin_q.oe && $stable(pin_q.bus))); // R6

    AST_CTRL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pin_q.ds_n |-> ($stable(pin_q.rw_n) && $stable(pin_q.dm_n))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pin_q.done |=> !pin_q.done); // R9

endmodule

// File: rtl/mbus_master.sv
module mbus_master
    import mbus_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int AS_CYC  = 2,
    parameter int RD_CYC  = 4,
    parameter int WR_CYC  = 2,
    parameter int EXT_CYC = 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     req_i,
    output logic                     ready_o,
    input  logic                     wr_i,
    input  logic                     mem_i,
    input  logic                     ext_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic                     done_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic [DATA_W-1:0]        bus_o,
    output logic                     bus_oe_o,
    input  logic [DATA_W-1:0]        bus_i,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic                     as_n_o,
    output logic                     ds_n_o,
    output logic                     rw_n_o,
    output logic                     dm_n_o
);

    phase_e ph_q;
    phase_e ph_d;
    logic   start;

    assign ready_o = (ph_q == PH_IDLE);
    assign start   = req_i && ready_o;

    mbus_fsm #(
        .AS_CYC  (AS_CYC),
        .RD_CYC  (RD_CYC),
        .WR_CYC  (WR_CYC),
        .EXT_CYC (EXT_CYC)
    ) i_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .wr_i    (wr_i),
        .ext_i   (ext_i),
        .ph_q_o  (ph_q),
        .ph_d_o  (ph_d)
    );

    mbus_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .AS_CYC (AS_CYC)
    ) i_pins (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .wr_i      (wr_i),
        .mem_i     (mem_i),
        .ph_q_i    (ph_q),
        .ph_d_i    (ph_d),
        .bus_i     (bus_i),
        .as_n_o    (as_n_o),
        .ds_n_o    (ds_n_o),
        .rw_n_o    (rw_n_o),
        .dm_n_o    (dm_n_o),
        .oe_o      (bus_oe_o),
        .bus_o     (bus_o),
        .addr_hi_o (addr_hi_o),
        .rdata_o   (rdata_o),
        .done_o    (done_o)
    );

endmodule

// File: tb/test_mbus_master.sv
module test_mbus_master;

    localparam int AS  = 2;
    localparam int RD  = 4;
    localparam int WR  = 2;
    localparam int EXT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        ready;
    logic        wr = 1'b0;
    logic        mem = 1'b0;
    logic        ext = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic [7:0]  bus_out;
    logic        bus_oe;
    logic [7:0]  bus_in = '0;
    logic [7:0]  addr_hi;
    logic        as_n, ds_n, rw_n, dm_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_rd = '0;

    always #2 clk = ~clk;

    mbus_master #(
        .ADDR_W (16), .DATA_W (8), .AS_CYC (AS),
        .RD_CYC (RD), .WR_CYC (WR), .EXT_CYC (EXT)
    ) i_mbus_master (
        .clk_i (clk), .rst_ni (rst_n), .req_i (req), .ready_o (ready),
        .wr_i (wr), .mem_i (mem), .ext_i (ext), .addr_i (addr),
        .wdata_i (wdata), .done_o (done), .rdata_o (rdata),
        .bus_o (bus_out), .bus_oe_o (bus_oe), .bus_i (bus_in),
        .addr_hi_o (addr_hi), .as_n_o (as_n), .ds_n_o (ds_n),
        .rw_n_o (rw_n), .dm_n_o (dm_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ds_len(input bit w, input bit x);
        return (w ? WR : RD) + (x ? EXT : 0);
    endfunction

    // 0 idle 1 setup 2 as 3 ahold 4 float 5 dset 6 ds 7 drise 8 done
    function automatic int phase_at(input int k, input bit w, input bit x);
        int d = ds_len(w, x);
        if (k == 1)             return 1;
        if (k <= 1 + AS)        return 2;
        if (k == 2 + AS)        return 3;
        if (k == 3 + AS)        return 4;
        if (k == 4 + AS)        return 5;
        if (k <= 4 + AS + d)    return 6;
        if (k == 5 + AS + d)    return 7;
        if (k == 6 + AS + d)    return 8;
        return 0;
    endfunction

    // {as_n, ds_n, oe, rw_n, dm_n, ready, done}
    function automatic logic [6:0] exp_pins(input int p, input bit w, input bit m);
        logic busy = (p >= 1) && (p <= 7);
        logic rwn  = busy ? ~w : 1'b1;
        logic dmn  = busy ? ~m : 1'b1;
        logic oe   = (p >= 1 && p <= 3) || (w && p >= 5 && p <= 7);
        return {(p != 2), (p != 6), oe, rwn, dmn, (p == 0), (p == 8)};
    endfunction

    function automatic string tag_of(input int p, input bit w, input bit x);
        case (p)
            1, 3: return "R2";
            2:    return "R3";
            4:    return "R4";
            5, 6, 7: return x ? "R7" : (w ? "R6" : "R5");
            8:    return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic run_txn(input bit w, input bit m, input bit x,
                           input logic [15:0] a, input logic [7:0] d, input bit junk);
        int n = 6 + AS + ds_len(w, x);
        int as_cnt = 0;
        int ds_cnt = 0;
        logic [7:0] cap = last_rd;
        chk(ready === 1'b1, "R1 ready before request", 32'(ready), 32'd1);
        req = 1'b1; wr = w; mem = m; ext = x; addr = a; wdata = d;
        for (int k = 1; k <= n + 1; k++) begin
            int p;
            logic [6:0] got, want;
            @(posedge clk); #1;
            p = phase_at(k, w, x);
            got  = {as_n, ds_n, bus_oe, rw_n, dm_n, ready, done};
            want = exp_pins(p, w, m);
            chk(got === want, tag_of(p, w, x), 32'(got), 32'(want));
            if (want[4]) begin
                logic [7:0] eb = (p <= 3) ? a[7:0] : d;
                chk(bus_out === eb, (p <= 3) ? "R2 bus addr" : "R6 bus wdata",
                    32'(bus_out), 32'(eb));
            end
            if (p >= 1 && p <= 7)
                chk(addr_hi === a[15:8], "R2 addr_hi", 32'(addr_hi), 32'(a[15:8]));
            if (!as_n) as_cnt++;
            if (!ds_n) ds_cnt++;
            if (p == 8) begin
                logic [7:0] er = w ? last_rd : cap;
                chk(rdata === er, "R5 rdata at done", 32'(rdata), 32'(er));
                chk(as_cnt == AS, "R3 as width", 32'(as_cnt), 32'(AS));
                chk(ds_cnt == ds_len(w, x), "R7 ds width", 32'(ds_cnt),
                    32'(ds_len(w, x)));
                last_rd = er;
            end
            // stimulus for the cycle now running
            bus_in = 8'($urandom);
            if (k == 4 + AS + ds_len(w, x)) cap = bus_in;
            if (junk && k < n) begin
                req = 1'b1; wr = 1'($urandom); mem = 1'($urandom);
                ext = 1'($urandom); addr = 16'($urandom); wdata = 8'($urandom);
            end else begin
                req = 1'b0;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk({as_n, ds_n, bus_oe, rw_n, dm_n, ready, done} === 7'b1101110,
            "R1 reset pins", 32'({as_n, ds_n, bus_oe, rw_n, dm_n, ready, done}),
            32'(7'b1101110));
        chk(rdata === 8'h00, "R1 reset rdata", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(ready === 1'b1, "R1 ready after reset", 32'(ready), 32'd1);
        // directed corners
        run_txn(1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0); // R5 plain read
        run_txn(1'b1, 1'b1, 1'b0, 16'hFFFF, 8'hA5, 1'b0); // R6 R8 write, memory
        run_txn(1'b0, 1'b1, 1'b1, 16'h1234, 8'h00, 1'b0); // R7 stretched read
        run_txn(1'b1, 1'b0, 1'b1, 16'h80FE, 8'h5A, 1'b1); // R7 stretched write, R1 junk
        run_txn(1'b0, 1'b0, 1'b0, 16'hC3C3, 8'h00, 1'b1); // R1 junk during read
        // constrained random
        for (int t = 0; t < 60; t++) begin
            run_txn(1'($urandom), 1'($urandom), 1'($urandom),
                    16'($urandom), 8'($urandom), 1'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R9 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule